// File: doc/BRIEF.md
# Lockstep Checkpoint Comparator with Retry Escalation

This block watches two copies of an execution engine that run the same instruction stream in lockstep. It does not compare their result buses on every cycle. It compares them only when a checkpoint strobe arrives. When the two results agree, the checkpoint is committed. When they disagree, the block orders the engines to roll back and re-execute from the last committed checkpoint. It then waits until the engines report that they are ready to resume.

The block counts retries that fail one after another. A mismatch is not fatal at once. Only when the count of consecutive failed retries has reached a configurable limit does a further mismatch stop the processor clock and request that a spare processor take over. That stop is sticky until reset.

A saturating tally of every mismatch seen is kept for error logging. The comparator splits the result bus into lanes so that the compare tree stays shallow.

Top module: `lockstep_retry_checker`

## Requirements
- R1: After a synchronous reset, commit_o, retry_o, clkstop_o and spare_req_o are 0 and mismatch_total_o is 0.
- R2: The result buses are compared only in a cycle where ckpt_i is 1. Different buses without a strobe produce no pulse and leave mismatch_total_o unchanged.
- R3: A checkpoint with equal buses in the running state raises commit_o for exactly the cycle after the strobe. It also resets the consecutive-retry count to 0.
- R4: A checkpoint with unequal buses, taken while the consecutive-retry count is below RETRY_LIMIT (default 2), raises retry_o for the one cycle after the strobe. It also adds one to the consecutive-retry count.
- R5: From the strobe that caused a retry until resume_i is sampled 1, the block ignores every strobe. This includes a strobe in the same cycle as resume_i. Strobes count again from the cycle after resume_i.
- R6: A checkpoint with unequal buses, taken while the consecutive-retry count equals RETRY_LIMIT, sets clkstop_o and spare_req_o from the next cycle on and gives no retry pulse. With the default limit, the third consecutive mismatch escalates.
- R7: clkstop_o and spare_req_o stay 1 until reset. While they are set, no commit or retry pulse appears and mismatch_total_o does not change.
- R8: mismatch_total_o rises by one the cycle after each accepted mismatching checkpoint, including the one that escalates. It holds at 2^ERR_W-1.
- R9: Any difference in any single bit of any lane of the buses counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ckpt_i | input | 1 | Checkpoint strobe |
| res_a_i | input | DATA_W | Result bus of engine A |
| res_b_i | input | DATA_W | Result bus of engine B |
| resume_i | input | 1 | Engines have rolled back and are ready to continue |
| commit_o | output | 1 | One-cycle pulse: checkpoint committed |
| retry_o | output | 1 | One-cycle pulse: roll back and re-execute |
| clkstop_o | output | 1 | Sticky: stop the processor clock |
| spare_req_o | output | 1 | Sticky: request dynamic sparing |
| mismatch_total_o | output | ERR_W | Saturating count of mismatches |

## Verification
Two events can fall in the same cycle: a checkpoint strobe and the resume signal that ends a retry. The bench raises both together while a retry is pending, in directed cases and also in the random stream. It expects no commit or retry pulse the next cycle and no change to mismatch_total_o. A strobe one cycle later must then be honoured. A second overlap is the escalating mismatch together with a saturated tally. It is judged by the tally holding while clkstop_o rises.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_HALT = 2'd2
    } lsc_state_e;

    typedef struct packed {
        logic commit;
        logic retry;
        logic halt;
    } lsc_ctl_t;

    function automatic int bits_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/lsc_lane_compare.sv
module lsc_lane_compare #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              mismatch_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_diff;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_diff[g] = |(a_i[g*LANE_W +: LANE_W] ^ b_i[g*LANE_W +: LANE_W]);
    end

    assign mismatch_o = |lane_diff;

    // R9: the lane tree agrees with a whole-bus inequality
    always_comb begin
        assert_lane_tree_R9: assert (mismatch_o == (a_i != b_i));
    end

endmodule

// File: rtl/lsc_sat_counter.sv
module lsc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (inc_i && count_q != TOP) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (count_q == TOP) |=> (count_q == TOP));

    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (inc_i && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> $stable(count_q));

endmodule

// File: rtl/lsc_retry_fsm.sv
module lsc_retry_fsm
    import lsc_pkg::*;
#(
    parameter int RETRY_LIMIT = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ckpt_i,
    input  logic     mismatch_i,
    input  logic     resume_i,
    output lsc_ctl_t ctl_o,
    output logic     err_event_o
);
    localparam int            CW    = bits_for(RETRY_LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(RETRY_LIMIT);

    lsc_state_e    state_q;
    logic [CW-1:0] consec_q;
    lsc_ctl_t      ctl_q;
    logic          accept;

    assign accept      = (state_q == ST_RUN) && ckpt_i;
    assign err_event_o = accept && mismatch_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            consec_q <= '0;
            ctl_q    <= '0;
        end else begin
            ctl_q.commit <= 1'b0;
            ctl_q.retry  <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (ckpt_i) begin
                        if (!mismatch_i) begin
                            ctl_q.commit <= 1'b1;
                            consec_q     <= '0;
                        end else if (consec_q == LIM_V) begin
                            ctl_q.halt <= 1'b1;
                            state_q    <= ST_HALT;
                        end else begin
                            ctl_q.retry <= 1'b1;
                            consec_q    <= consec_q + 1'b1;
                            state_q     <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (resume_i) begin
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    assign ctl_o = ctl_q;

    assert_no_double_R4: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.commit && ctl_q.retry));

    assert_consec_bound_R6: assert property (@(posedge clk) disable iff (rst)
        consec_q <= LIM_V);

    assert_hold_ignores_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && ckpt_i) |=> (!ctl_q.commit && !ctl_q.retry));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_q.halt |=> ctl_q.halt);

    assert_quiet_after_halt_R7: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_q.halt) |-> (!ctl_q.commit && !ctl_q.retry));

    assert_match_commits_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !mismatch_i) |=> (ctl_q.commit && consec_q == '0));

endmodule

// File: rtl/lockstep_retry_checker.sv
module lockstep_retry_checker
    import lsc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LANE_W      = 8,
    parameter int RETRY_LIMIT = 2,
    parameter int ERR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ckpt_i,
    input  logic [DATA_W-1:0] res_a_i,
    input  logic [DATA_W-1:0] res_b_i,
    input  logic              resume_i,
    output logic              commit_o,
    output logic              retry_o,
    output logic              clkstop_o,
    output logic              spare_req_o,
    output logic [ERR_W-1:0]  mismatch_total_o
);
    logic     mismatch;
    logic     err_event;
    lsc_ctl_t ctl;

    lsc_lane_compare #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) i_compare (
        .a_i        (res_a_i),
        .b_i        (res_b_i),
        .mismatch_o (mismatch)
    );

    lsc_retry_fsm #(
        .RETRY_LIMIT (RETRY_LIMIT)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .ckpt_i      (ckpt_i),
        .mismatch_i  (mismatch),
        .resume_i    (resume_i),
        .ctl_o       (ctl),
        .err_event_o (err_event)
    );

    lsc_sat_counter #(
        .W (ERR_W)
    ) i_tally (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (err_event),
        .count_o (mismatch_total_o)
    );

    assign commit_o    = ctl.commit;
    assign retry_o     = ctl.retry;
    assign clkstop_o   = ctl.halt;
    assign spare_req_o = ctl.halt;

    assert_tally_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        clkstop_o |=> $stable(mismatch_total_o));

endmodule

// File: tb/test_lockstep_retry_checker.sv
module test_lockstep_retry_checker;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW  = 32;
    localparam int LIM = 2;
    localparam int EW  = 5;
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ckpt = 1'b0;
    logic resume = 1'b0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic commit, retry, clkstop, spare;
    logic [EW-1:0] total;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt, m_consec;
    bit m_hold, m_halt;
    bit e_commit, e_retry;

    always #2.5 clk = ~clk;

    lockstep_retry_checker #(
        .DATA_W (DW), .LANE_W (8), .RETRY_LIMIT (LIM), .ERR_W (EW)
    ) i_lockstep_retry_checker (
        .clk (clk), .rst (rst), .ckpt_i (ckpt), .res_a_i (a), .res_b_i (b),
        .resume_i (resume), .commit_o (commit), .retry_o (retry),
        .clkstop_o (clkstop), .spare_req_o (spare), .mismatch_total_o (total)
    );

    function automatic bit differs(input logic [DW-1:0] x, input logic [DW-1:0] y);
        return x != y;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(commit == e_commit, tag, "commit_o", int'(commit), int'(e_commit));
        check(retry == e_retry, tag, "retry_o", int'(retry), int'(e_retry));
        check(clkstop == m_halt, tag, "clkstop_o", int'(clkstop), int'(m_halt));
        check(spare == m_halt, tag, "spare_req_o", int'(spare), int'(m_halt));
        check(int'(total) == m_cnt, tag, "mismatch_total_o", int'(total), m_cnt);
    endtask

    // one cycle: inputs applied at a falling edge, outputs checked at the next one
    task automatic step(input bit ck, input logic [DW-1:0] xa, input logic [DW-1:0] xb,
                        input bit rs, input string tag);
        ckpt = ck; a = xa; b = xb; resume = rs;
        e_commit = 0; e_retry = 0;
        if (!m_halt && !m_hold && ck) begin
            if (!differs(xa, xb)) begin
                e_commit = 1; m_consec = 0;
            end else begin
                if (m_cnt < int'(EMAX)) m_cnt++;
                if (m_consec == LIM) m_halt = 1;
                else begin m_consec++; e_retry = 1; m_hold = 1; end
            end
        end else if (m_hold && rs) begin
            m_hold = 0;
        end
        @(posedge clk);
        @(negedge clk);
        ckpt = 0; resume = 0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1; ckpt = 0; resume = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_cnt = 0; m_consec = 0; m_hold = 0; m_halt = 0;
        e_commit = 0; e_retry = 0;
        check_all("R1");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] x;
        int seed_dummy;
        @(negedge clk);
        do_reset();                                                     // R1
        step(0, 32'h1234_5678, 32'h0000_0000, 0, "R2");                 // no strobe, buses differ
        step(1, 32'hCAFE_0001, 32'hCAFE_0001, 0, "R3");                 // commit
        step(1, 32'hCAFE_0001, 32'h4AFE_0001, 0, "R9");                 // top bit of last lane
        step(1, 32'h0, 32'h1, 0, "R5");                                 // ignored while holding
        step(1, 32'h0, 32'h1, 1, "R5");                                 // strobe with resume ignored
        step(1, 32'h5, 32'h5, 0, "R5");                                 // honoured again
        step(1, 32'h0, 32'h0000_0100, 0, "R4");                         // lane 1 bit
        step(0, 32'h0, 32'h0, 1, "R4");
        step(1, 32'h0, 32'h0001_0000, 0, "R4");                         // second retry
        step(0, 32'h0, 32'h0, 1, "R4");
        step(1, 32'h0, 32'h0000_0001, 0, "R6");                         // third: escalate
        step(1, 32'h7, 32'h7, 0, "R7");
        step(1, 32'h7, 32'h8, 0, "R7");
        step(0, 32'h0, 32'h0, 1, "R7");
        do_reset();
        // match clears the consecutive count
        step(1, 32'h1, 32'h2, 0, "R3");
        step(0, 32'h0, 32'h0, 1, "R3");
        step(1, 32'h1, 32'h2, 0, "R3");
        step(0, 32'h0, 32'h0, 1, "R3");
        step(1, 32'h9, 32'h9, 0, "R3");
        step(1, 32'h1, 32'h2, 0, "R3");                                 // retry, not halt
        step(0, 32'h0, 32'h0, 1, "R3");
        // saturation of the tally
        for (int i = 0; i < 40; i++) begin
            step(1, 32'hF0F0, 32'hF0F1, 0, "R8");
            step(0, 32'h0, 32'h0, 1, "R8");
            step(1, 32'hAAAA, 32'hAAAA, 0, "R8");
        end
        step(1, 32'h1, 32'h0, 0, "R8");
        step(0, 32'h0, 32'h0, 1, "R8");
        step(1, 32'h1, 32'h0, 0, "R8");
        step(0, 32'h0, 32'h0, 1, "R8");
        step(1, 32'h1, 32'h0, 0, "R8");                                 // escalate with full tally
        check(int'(total) == int'(EMAX), "R8", "saturated", int'(total), int'(EMAX));
        do_reset();
        // random phase
        seed_dummy = int'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            x  = $urandom();
            if (m_halt && op < 2) begin
                do_reset();
            end else if (op < 4) begin
                step(1, x, x, m_hold && op == 3, "R3");
            end else if (op < 7) begin
                step(1, x, x ^ (32'd1 << $urandom_range(0, DW-1)), m_hold && op == 6, "R4");
            end else if (op < 9) begin
                step(0, 32'h0, 32'h0, 1, "R5");
            end else begin
                step(0, x, ~x, 0, "R2");
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule